// File: doc/BRIEF.md
# Auxiliary Serial Port Control Register

This block is one control word of an audio codec's register file, the word that governs an auxiliary serial output port. It stores a master serial-data enable, an enable for a second data output, an enable for an outgoing serial clock and a two-bit data-format code. Both serial outputs use the same format code. The host reaches the word through an indexed read/write interface. A write is accepted only when the address equals the word's index, which is `7'h6A` by default.

The block checks each write against the other bits and against an external power-down flag. It clears dependent bits when the master enable drops, and it masks the clock-enable bit on readback. Two GPIO pins (0 and 1) are shared with the master serial function, and a third pin (4) is shared with the second output. The block gives each of these three pins a configuration level. It also gives one-cycle set and clear pulses that a neighbouring GPIO configuration register uses to update its bits. The serial data path, the other registers and the host link are not part of this block.

Top module: `sport_ctl_reg`

## Requirements
- R1: After reset the word reads 0000h. All enables and the format code are 0, `gpio_cfg` is 3'b111, and both pulse vectors are 0.
- R2: The master enable is bit 15 and the format code is bits 1:0. Both take the written value. Bits 14:4 are reserved: writes to them are ignored and they read 0.
- R3: The second-output enable (bit 3) takes a written 1 only when the same write leaves the master enable at 1. This includes a write that sets the master enable at the same time.
- R4: The clock enable (bit 2) takes a written 1 only when the same write leaves the master enable at 1 and `pwrdn` is 0.
- R5: A write that clears the master enable also clears the second-output enable and the clock enable in the same update.
- R6: If `pwrdn` is 1 while the clock enable is set, the clock enable is 0 after the next clock edge and stays 0 until a later qualified write.
- R7: Readback bit 2 is 0 in any cycle where the master enable is 0 or `pwrdn` is 1. This masking takes effect at once, before the stored bit is cleared.
- R8: `gpio_cfg[1:0]` are both the inverse of the master enable. A rise of the master enable gives `gcfg_clr[1:0]`=2'b11 for one cycle, and a fall gives `gcfg_set[1:0]`=2'b11 for one cycle.
- R9: `gpio_cfg[2]` is the inverse of the second-output enable. A rise of that enable pulses `gcfg_clr[2]` and a fall pulses `gcfg_set[2]`, each for one cycle. No bit is ever pulsed in both vectors at once.
- R10: A write to any other index leaves the word unchanged. Reading any other index returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Register index for the read and the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Readback for the addressed index (combinational) |
| pwrdn | input | 1 | External power-down flag |
| ser_en | output | 1 | Master serial-data enable |
| ser2_en | output | 1 | Second-output enable |
| sclk_en | output | 1 | Serial-clock enable |
| data_fmt | output | 2 | Format code shared by both outputs |
| gpio_cfg | output | 3 | Pin-as-GPIO level for pins 0, 1 and 4 (bits 0, 1, 2) |
| gcfg_set | output | 3 | One-cycle pulse that sets the pin configuration bits |
| gcfg_clr | output | 3 | One-cycle pulse that clears the pin configuration bits |

## Verification
Two events can fall in the same cycle: a write that changes the master enable, and an automatic change to a dependent bit together with its GPIO side effect. The bench writes 0000h while every enable is set. It then expects the dependent bits to clear and all three set pulses to appear on that same edge. The bench also writes master and dependent bits together from the disabled state, and expects both the acceptance and a three-bit clear pulse. A second overlap is power-down arriving while the clock enable is live. Here the bench checks the readback mask before the edge and the stored clear after it.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int DW      = 16;
    localparam int MEN_BIT = 15;
    localparam int S2_BIT  = 3;
    localparam int CK_BIT  = 2;
    localparam int FMT_W   = 2;
    localparam int NPIN    = 3;

    typedef struct packed {
        logic             men;
        logic             s2en;
        logic             cken;
        logic [FMT_W-1:0] fmt;
        logic [NPIN-1:0]  gset;
        logic [NPIN-1:0]  gclr;
    } sport_st_t;
endpackage

// File: rtl/sport_wr_qual.sv
module sport_wr_qual
    import sport_pkg::*;
#(
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] REG_INDEX = 7'h6A
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     wdata,
    input  logic              pwrdn,
    input  logic              men_q,
    input  logic              s2en_q,
    input  logic              cken_q,
    input  logic [FMT_W-1:0]  fmt_q,
    output logic              men_d,
    output logic              s2en_d,
    output logic              cken_d,
    output logic [FMT_W-1:0]  fmt_d
);
    logic hit;

    always_comb begin
        hit    = reg_wr && (reg_addr == REG_INDEX);
        men_d  = men_q;
        s2en_d = s2en_q & men_q;
        cken_d = cken_q & men_q & ~pwrdn;
        fmt_d  = fmt_q;
        if (hit) begin
            men_d  = wdata[MEN_BIT];
            s2en_d = wdata[S2_BIT] & men_d;
            cken_d = wdata[CK_BIT] & men_d & ~pwrdn;
            fmt_d  = wdata[FMT_W-1:0];
        end
    end
endmodule

// File: rtl/sport_gpio_fx.sv
module sport_gpio_fx #(
    parameter int NPIN = 3
) (
    input  logic [NPIN-1:0] own_q,
    input  logic [NPIN-1:0] own_d,
    output logic [NPIN-1:0] cfg,
    output logic [NPIN-1:0] set_d,
    output logic [NPIN-1:0] clr_d
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign cfg[i]   = ~own_q[i];
        assign set_d[i] = own_q[i] & ~own_d[i];
        assign clr_d[i] = ~own_q[i] & own_d[i];
    end
endmodule

// File: rtl/sport_rdmux.sv
module sport_rdmux
    import sport_pkg::*;
#(
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] REG_INDEX = 7'h6A
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              pwrdn,
    input  logic              men_q,
    input  logic              s2en_q,
    input  logic              cken_q,
    input  logic [FMT_W-1:0]  fmt_q,
    output logic [DW-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        if (reg_addr == REG_INDEX) begin
            rdata[MEN_BIT]     = men_q;
            rdata[S2_BIT]      = s2en_q;
            rdata[CK_BIT]      = cken_q & men_q & ~pwrdn;
            rdata[FMT_W-1:0]   = fmt_q;
        end
    end
endmodule

// File: rtl/sport_ctl_reg.sv
module sport_ctl_reg
    import sport_pkg::*;
#(
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] REG_INDEX = 7'h6A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              pwrdn,
    output logic              ser_en,
    output logic              ser2_en,
    output logic              sclk_en,
    output logic [FMT_W-1:0]  data_fmt,
    output logic [NPIN-1:0]   gpio_cfg,
    output logic [NPIN-1:0]   gcfg_set,
    output logic [NPIN-1:0]   gcfg_clr
);
    sport_st_t        st_d, st_q;
    logic             men_n, s2en_n, cken_n;
    logic [FMT_W-1:0] fmt_n;
    logic [NPIN-1:0]  own_q, own_d, set_n, clr_n;

    sport_wr_qual #(.ADDR_W(ADDR_W), .REG_INDEX(REG_INDEX)) u_qual (
        .reg_wr (reg_wr),    .reg_addr(reg_addr), .wdata (reg_wdata),
        .pwrdn  (pwrdn),     .men_q   (st_q.men), .s2en_q(st_q.s2en),
        .cken_q (st_q.cken), .fmt_q   (st_q.fmt), .men_d (men_n),
        .s2en_d (s2en_n),    .cken_d  (cken_n),   .fmt_d (fmt_n)
    );

    // pin 0 and pin 1 follow the master enable, pin 4 the second output
    assign own_q = {st_q.s2en, st_q.men, st_q.men};
    assign own_d = {s2en_n, men_n, men_n};

    sport_gpio_fx #(.NPIN(NPIN)) u_gpio (
        .own_q(own_q), .own_d(own_d), .cfg(gpio_cfg),
        .set_d(set_n), .clr_d(clr_n)
    );

    sport_rdmux #(.ADDR_W(ADDR_W), .REG_INDEX(REG_INDEX)) u_rd (
        .reg_addr(reg_addr), .pwrdn(pwrdn), .men_q(st_q.men),
        .s2en_q(st_q.s2en), .cken_q(st_q.cken), .fmt_q(st_q.fmt),
        .rdata(reg_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.men  = men_n;
        st_d.s2en = s2en_n;
        st_d.cken = cken_n;
        st_d.fmt  = fmt_n;
        st_d.gset = set_n;
        st_d.gclr = clr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_en   = st_q.men;
    assign ser2_en  = st_q.s2en;
    assign sclk_en  = st_q.cken;
    assign data_fmt = st_q.fmt;
    assign gcfg_set = st_q.gset;
    assign gcfg_clr = st_q.gclr;

    // ---------------- assertions ----------------
    logic wr_hit, wr_rsvd;
    assign wr_hit  = reg_wr && (reg_addr == REG_INDEX);
    assign wr_rsvd = |reg_wdata[MEN_BIT-1:S2_BIT+1];

    assert_rsvd_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_rsvd) |=> (reg_rdata[MEN_BIT-1:S2_BIT+1] == '0));

    assert_s2_needs_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ser2_en |-> ser_en);

    assert_clk_rise_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_en) |-> (ser_en && !$past(pwrdn)));

    assert_clk_needs_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_en |-> ser_en);

    assert_pwrdn_clears_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn && sclk_en) |=> !sclk_en);

    assert_rd_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn || !ser_en) |-> !reg_rdata[CK_BIT]);

    assert_master_rise_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_en) |-> (gcfg_clr[1:0] == 2'b11));

    assert_no_set_clr_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gcfg_set & gcfg_clr) == '0);

    assert_other_index_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(ser_en) && $stable(data_fmt)));
endmodule

// File: tb/sport_ctl_reg_test.sv
module sport_ctl_reg_test;
    localparam logic [6:0] IDX = 7'h6A;

    typedef struct packed {
        logic [15:0] rdata;
        logic        m, s2, ck;
        logic [1:0]  fmt;
        logic [2:0]  cfg, gs, gc;
    } obs_t;

    typedef struct {
        obs_t  v;
        string tag;
    } item_t;

    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, pwrdn = 0;
    logic [6:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ser_en, ser2_en, sclk_en;
    logic [1:0]  data_fmt;
    logic [2:0]  gpio_cfg, gcfg_set, gcfg_clr;

    int tests = 0, fails = 0;
    bit done = 0;
    item_t q[$];

    // model state
    bit       m_m = 0, m_s2 = 0, m_ck = 0;
    bit [1:0] m_fmt = 0;

    always #10 clk = ~clk;

    sport_ctl_reg uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwrdn(pwrdn),
        .ser_en(ser_en), .ser2_en(ser2_en), .sclk_en(sclk_en),
        .data_fmt(data_fmt), .gpio_cfg(gpio_cfg), .gcfg_set(gcfg_set),
        .gcfg_clr(gcfg_clr)
    );

    function automatic obs_t actual();
        obs_t o;
        o.rdata = reg_rdata; o.m = ser_en; o.s2 = ser2_en; o.ck = sclk_en;
        o.fmt = data_fmt; o.cfg = gpio_cfg; o.gs = gcfg_set; o.gc = gcfg_clr;
        return o;
    endfunction

    task automatic check(input obs_t act, input obs_t exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, pushes expected outputs after the edge
    task automatic step(input bit wr, input logic [6:0] a, input logic [15:0] d,
                        input bit pd, input string tag);
        item_t it;
        bit pm, ps2;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; pwrdn = pd;
        pm = m_m; ps2 = m_s2;
        if (wr && a == IDX) begin
            m_m   = d[15];
            m_s2  = d[3] & m_m;
            m_ck  = d[2] & m_m & ~pd;
            m_fmt = d[1:0];
        end else begin
            m_ck = m_ck & ~pd;
        end
        it.tag     = tag;
        it.v.rdata = (a == IDX) ? {m_m, 11'b0, m_s2, m_ck & m_m & ~pd, m_fmt} : 16'h0;
        it.v.m = m_m; it.v.s2 = m_s2; it.v.ck = m_ck; it.v.fmt = m_fmt;
        it.v.cfg = {~m_s2, ~m_m, ~m_m};
        it.v.gs  = {ps2 & ~m_s2, pm & ~m_m, pm & ~m_m};
        it.v.gc  = {~ps2 & m_s2, ~pm & m_m, ~pm & m_m};
        @(posedge clk);
        #2;
        q.push_back(it);
    endtask

    // monitor: compares after each edge, away from the driving negedge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            check(actual(), e.v, e.tag);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step(0, IDX, 16'h0000, 0, "R1 reset state");
        step(1, IDX, 16'h000F, 0, "R3 R4 dependents refused while master off");
        step(1, IDX, 16'h8001, 0, "R8 master set clears pin 0/1 cfg");
        step(0, IDX, 16'h0000, 0, "R8 pulse lasts one cycle");
        step(1, IDX, 16'h8009, 0, "R9 second output set clears pin 4 cfg");
        step(1, IDX, 16'h800D, 1, "R4 clock refused under power-down");
        step(1, IDX, 16'h800E, 0, "R4 clock accepted, R2 format written");
        // R7: mask before the stored bit clears
        @(negedge clk);
        reg_wr = 0; reg_addr = IDX; pwrdn = 1;
        #1;
        tests++;
        if (reg_rdata[2] !== 1'b0 || sclk_en !== 1'b1) begin
            fails++;
            $display("FAIL R7 actual rd2=%b sclk=%b expected rd2=0 sclk=1",
                     reg_rdata[2], sclk_en);
        end
        step(0, IDX, 16'h0000, 1, "R6 power-down clears clock enable");
        step(0, IDX, 16'h0000, 0, "R6 clock stays off after power-down ends");
        step(1, IDX, 16'hFFFF, 0, "R2 reserved bits ignored");
        step(1, 7'h20, 16'h0000, 0, "R10 other index write ignored, reads 0");
        step(0, IDX, 16'h0000, 0, "R10 word unchanged");
        step(1, IDX, 16'h0000, 0, "R5 R8 R9 master drop auto-clears, set pulses");
        step(1, IDX, 16'h800C, 0, "R3 R4 same-write acceptance, clr pulses");
        step(0, 7'h6B, 16'h0000, 0, "R10 neighbour index reads 0");
        step(1, IDX, 16'h0004, 0, "R5 clock alone refused with master off");
        step(0, IDX, 16'h0000, 0, "R9 pulses settle");
        @(posedge clk); #8;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule